// File: doc/BRIEF.md
# I2C Register Slave with Strap-Selected Address

This block is a two-wire serial slave that gives a host processor read and write access to a small file of 8-bit control registers. SCL and SDA arrive as open-drain pad inputs and are oversampled by a fast system clock. The block answers only on SDA, and only by pulling it low. It never drives SCL. On the other side it presents a simple register port: a pointer, write data, a one-cycle write strobe, and a read-data input that the register file must return combinationally for the current pointer.

The seven-bit bus address comes from a three-level strap input, which is captured once after reset. Four transaction shapes are supported:
- A register write: address, command byte, data byte.
- A register read: address, command byte, repeated START, address with read, data byte.
- A pointer-only command.
- A pointer-only read that returns whichever register the last command selected.

Short spikes on both lines are filtered out. If SDA stays low for too long, the state machine abandons the transfer and lets SDA go. Each transfer addressed to this slave produces a single-cycle pulse when it ends, which an external watchdog can use as evidence of bus activity.

Top module: `i2c_strap_slave`

## Requirements
- R1: The address is captured from `strap_lvl` in the first cycle after reset and held until the next reset: 0 selects 0x50, 2 selects ADDR_VCC (default 0x54), and 1 or 3 selects 0x52. Changes on `strap_lvl` after that cycle have no effect.
- R2: If the address byte does not match, the slave does not acknowledge it. It then ignores every following byte until the next START: no write strobe, no pointer change and no `valid_txn`.
- R3: In a write, the byte after the address sets the pointer and the next byte appears on `reg_wdata`. At that point `reg_we` pulses for exactly one cycle, with `reg_addr` equal to the command byte.
- R4: A command byte followed directly by STOP only loads the pointer. `reg_addr` then shows the command value.
- R5: In a read-byte transfer (address+W, command, repeated START, address+R), the slave shifts out `reg_rdata` for the commanded register, MSB first.
- R6: A read that begins directly with address+R returns the register selected by the current pointer.
- R7: The slave acknowledges by holding SDA low through the whole high phase of the ninth clock. `sda_oe` only rises while the filtered SCL is low.
- R8: A pulse on SCL or SDA shorter than FILT_N clock cycles has no effect on the transfer in progress.
- R9: If SDA stays low for TMO_CYC cycles during a transfer, the slave releases SDA and returns to idle. No `valid_txn` follows.
- R10: At STOP, `valid_txn` pulses for one cycle if the address byte of the transfer was acknowledged, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock pad input |
| sda_i | input | 1 | Serial data pad input (wired bus level) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| strap_lvl | input | 2 | Address strap level: 0 ground, 1 open, 2 supply |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Data for a register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register content at `reg_addr` |
| valid_txn | output | 1 | One-cycle pulse at STOP after an addressed transfer |

## Verification
The assertions depend on three properties of the bus. Both lines are held steady for well over FILT_N cycles between real transitions. The master changes SDA only while SCL is low, except when it forms START or STOP. The register file answers `reg_rdata` without delay. The stimulus meets these by spacing every bus edge a quarter-bit of 25 clocks apart, far longer than the filter and detector latency. The only deliberately short pulses are six-cycle glitches, and the timeout case is the only place where SCL is held high long enough to exceed TMO_CYC.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK,
    ST_WAIT
  } slv_st_e;

  typedef enum logic [1:0] {
    STRAP_GND  = 2'd0,
    STRAP_OPEN = 2'd1,
    STRAP_VCC  = 2'd2
  } strap_e;
endpackage

// File: rtl/i2c_rs_filt.sv
module i2c_rs_filt #(
  parameter int FILT_N = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_N + 1);

  logic          s1_q, s2_q, filt_q, filt_nx;
  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    filt_nx = filt_q;
    cnt_nx  = '0;
    if (s2_q != filt_q) begin
      if (cnt_q == CW'(FILT_N - 1)) begin
        filt_nx = s2_q;
      end else begin
        cnt_nx = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      cnt_q  <= cnt_nx;
      filt_q <= filt_nx;
    end
  end

  assign line_o = filt_q;

  // R8: the filtered level only moves after the synchronised input has disagreed with it
  p_filt_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(s2_q) == filt_q));
endmodule

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign start_p  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_p   = scl_f & scl_d & ~sda_d & sda_f;
  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
endmodule

// File: rtl/i2c_rs_tmo.sv
module i2c_rs_tmo #(
  parameter int TMO_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic sda_f,
  output logic hit
);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [TW-1:0] cnt_q, cnt_nx;

  always_comb begin
    hit    = 1'b0;
    cnt_nx = '0;
    if (arm && !sda_f) begin
      if (cnt_q == TW'(TMO_CYC - 1)) begin
        hit = 1'b1;
      end else begin
        cnt_nx = cnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
  import i2c_rs_pkg::*;
#(
  parameter int TMO_CYC = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] my_addr,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic [7:0] reg_rdata,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic       valid_txn
);
  slv_st_e    st_q, st_nx;
  logic [3:0] cnt_q, cnt_nx;
  logic [7:0] sr_q, sr_nx, ptr_q, ptr_nx, wd_q, wd_nx;
  logic       oe_q, oe_nx, we_q, we_nx, rw_q, rw_nx;
  logic       ok_q, ok_nx, vld_q, vld_nx;
  logic       tmo_hit;

  i2c_rs_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (st_q != ST_IDLE),
    .sda_f (sda_f),
    .hit   (tmo_hit)
  );

  always_comb begin
    st_nx  = st_q;
    cnt_nx = cnt_q;
    sr_nx  = sr_q;
    ptr_nx = ptr_q;
    wd_nx  = wd_q;
    oe_nx  = oe_q;
    rw_nx  = rw_q;
    ok_nx  = ok_q;
    we_nx  = 1'b0;
    vld_nx = 1'b0;
    if (tmo_hit) begin
      st_nx = ST_IDLE;
      oe_nx = 1'b0;
      ok_nx = 1'b0;
    end else if (start_p) begin
      st_nx  = ST_ADDR;
      cnt_nx = '0;
      oe_nx  = 1'b0;
    end else if (stop_p) begin
      vld_nx = ok_q && (st_q != ST_IDLE);
      st_nx  = ST_IDLE;
      oe_nx  = 1'b0;
      ok_nx  = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_CMD, ST_WDAT: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sr_nx  = {sr_q[6:0], sda_f};
            cnt_nx = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_nx = '0;
            if (st_q == ST_ADDR) begin
              if (sr_q[7:1] == my_addr) begin
                oe_nx = 1'b1;
                rw_nx = sr_q[0];
                ok_nx = 1'b1;
                st_nx = ST_ADDR_ACK;
              end else begin
                ok_nx = 1'b0;
                st_nx = ST_WAIT;
              end
            end else if (st_q == ST_CMD) begin
              oe_nx  = 1'b1;
              ptr_nx = sr_q;
              st_nx  = ST_CMD_ACK;
            end else begin
              oe_nx = 1'b1;
              we_nx = 1'b1;
              wd_nx = sr_q;
              st_nx = ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_nx = '0;
            if (rw_q) begin
              sr_nx = reg_rdata;
              oe_nx = ~reg_rdata[7];
              st_nx = ST_RDAT;
            end else begin
              oe_nx = 1'b0;
              st_nx = ST_CMD;
            end
          end
        end
        ST_CMD_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            oe_nx = 1'b0;
            st_nx = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_nx = 1'b0;
              st_nx = ST_RDAT_ACK;
            end else begin
              cnt_nx = cnt_q + 4'd1;
              sr_nx  = {sr_q[6:0], 1'b0};
              oe_nx  = ~sr_q[6];
            end
          end
        end
        ST_RDAT_ACK: begin
          if (scl_rise) st_nx = sda_f ? ST_WAIT : ST_ADDR_ACK;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sr_q  <= '0;
      ptr_q <= '0;
      wd_q  <= '0;
      oe_q  <= 1'b0;
      we_q  <= 1'b0;
      rw_q  <= 1'b0;
      ok_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_nx;
      cnt_q <= cnt_nx;
      sr_q  <= sr_nx;
      ptr_q <= ptr_nx;
      oe_q  <= oe_nx;
      we_q  <= we_nx;
      rw_q  <= rw_nx;
      ok_q  <= ok_nx;
      vld_q <= vld_nx;
      if (we_nx) wd_q <= wd_nx;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_addr  = ptr_q;
  assign reg_wdata = wd_q;
  assign reg_we    = we_q;
  assign valid_txn = vld_q;

  // R7: the slave begins pulling SDA only while SCL is low
  p_oe_rise_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_f);
  // R3: a register write is a single-cycle strobe
  p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);
  // R10: the transaction pulse lasts one cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  // R9: a timeout frees SDA and idles the engine
  p_tmo_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (!oe_q && st_q == ST_IDLE));
  // R2: while waiting out a foreign transfer the slave leaves SDA alone
  p_wait_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !oe_q);
endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2c_rs_pkg::*;
#(
  parameter int         FILT_N    = 13,
  parameter int         TMO_CYC   = 4000,
  parameter logic [6:0] ADDR_GND  = 7'h50,
  parameter logic [6:0] ADDR_OPEN = 7'h52,
  parameter logic [6:0] ADDR_VCC  = 7'h54
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_lvl,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata,
  output logic       valid_txn
);
  localparam int NLINE = 2;

  logic [1:0]       rst_q;
  logic             rst_s;
  logic [NLINE-1:0] raw_v, filt_v;
  logic             start_p, stop_p, scl_rise, scl_fall;
  logic [6:0]       strap_addr, my_addr;
  logic             strap_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  assign raw_v = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_filt
    i2c_rs_filt #(.FILT_N(FILT_N)) u_filt (
      .clk    (clk),
      .rst_n  (rst_s),
      .line_i (raw_v[g]),
      .line_o (filt_v[g])
    );
  end

  always_comb begin
    unique case (strap_e'(strap_lvl))
      STRAP_GND: strap_addr = ADDR_GND;
      STRAP_VCC: strap_addr = ADDR_VCC;
      default:   strap_addr = ADDR_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      my_addr    <= ADDR_GND;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      my_addr    <= strap_addr;
      strap_done <= 1'b1;
    end
  end

  i2c_rs_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_s),
    .scl_f    (filt_v[0]),
    .sda_f    (filt_v[1]),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  i2c_rs_fsm #(.TMO_CYC(TMO_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s),
    .my_addr   (my_addr),
    .scl_f     (filt_v[0]),
    .sda_f     (filt_v[1]),
    .start_p   (start_p),
    .stop_p    (stop_p),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .valid_txn (valid_txn)
  );

  // R1: once captured, the strap address holds until reset
  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_s)
    strap_done |=> $stable(my_addr));
endmodule

// File: tb/i2c_strap_slave_bench.sv
module i2c_strap_slave_bench;
  localparam int Q = 25;
  localparam int TMO = 4000;

  logic       clk = 1'b0;
  logic       rst_n, scl_m, sda_m, sda_oe, reg_we, valid_txn;
  logic [1:0] strap;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_line;

  logic [7:0] mem    [0:255];
  logic [7:0] expmem [0:255];
  logic [15:0] wq[$];

  int checks = 0, errs = 0, m_checks = 0, m_errs = 0, vcount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_strap_slave u_i2c_strap_slave (
    .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_line),
    .sda_oe (sda_oe), .strap_lvl (strap), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_we (reg_we), .reg_rdata (reg_rdata),
    .valid_txn (valid_txn)
  );

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  // scoreboard monitor: each strobe must match the next expected write (R3)
  always @(negedge clk) begin
    if (valid_txn) vcount++;
    if (reg_we) begin
      m_checks++;
      if (wq.size() == 0) begin
        m_errs++;
        $display("FAIL R3 unexpected write act=%h%h exp=none", reg_addr, reg_wdata);
      end else begin
        logic [15:0] e;
        e = wq.pop_front();
        if ({reg_addr, reg_wdata} != e) begin
          m_errs++;
          $display("FAIL R3 write act=%h%h exp=%h", reg_addr, reg_wdata, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic qd(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; qd(); sda_m = 1'b0; qd(); scl_m = 1'b0; qd();
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; qd(); scl_m = 1'b1; qd(); sda_m = 1'b0; qd(); scl_m = 1'b0; qd();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qd(); scl_m = 1'b1; qd(); sda_m = 1'b1; qd();
  endtask

  task automatic wbit(input bit b, input bit sglitch);
    sda_m = b; qd(); scl_m = 1'b1; qd();
    if (sglitch) begin
      sda_m = 1'b0; repeat (6) @(negedge clk); sda_m = b;
    end
    qd(); scl_m = 1'b0; qd();
  endtask

  task automatic wbyte(input logic [7:0] d, input bit glitch, output bit ack);
    bit s1, s2;
    for (int i = 7; i >= 0; i--) wbit(d[i], glitch && i == 4 && d[i]);
    sda_m = 1'b1; qd(); scl_m = 1'b1; qd(); s1 = sda_line; qd(); s2 = sda_line;
    scl_m = 1'b0; qd();
    ack = !s1 && !s2;
  endtask

  task automatic rbyte(output logic [7:0] d, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; qd(); scl_m = 1'b1; qd(); d[i] = sda_line; qd();
      scl_m = 1'b0; qd();
    end
    wbit(!mack, 1'b0);
  endtask

  task automatic scl_glitch();
    scl_m = 1'b1; repeat (6) @(negedge clk); scl_m = 1'b0; qd();
  endtask

  task automatic do_reset(input logic [1:0] s);
    strap = s; rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk); rst_n = 1'b1; repeat (10) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                        input bit expect_ack, input bit glitch, input string req);
    bit ack, a2;
    int v0;
    v0 = vcount;
    bus_start();
    wbyte({a, 1'b0}, 1'b0, ack);
    chk(ack == expect_ack, req, {15'd0, ack}, {15'd0, expect_ack});
    if (glitch) scl_glitch();
    if (expect_ack) begin
      wq.push_back({c, d});
      expmem[c] = d;
    end
    wbyte(c, 1'b0, a2);
    wbyte(d, glitch, a2);
    bus_stop(); qd();
    chk(vcount == v0 + (expect_ack ? 1 : 0), "R10", 16'(vcount - v0), {15'd0, expect_ack});
  endtask

  task automatic rd_reg(input logic [6:0] a, input logic [7:0] c);
    bit ack;
    logic [7:0] d;
    bus_start();
    wbyte({a, 1'b0}, 1'b0, ack);
    wbyte(c, 1'b0, ack);
    bus_restart();
    wbyte({a, 1'b1}, 1'b0, ack);
    chk(ack, "R7", {15'd0, ack}, 16'd1);
    rbyte(d, 1'b0);
    bus_stop(); qd();
    chk(d == expmem[c], "R5", {8'd0, d}, {8'd0, expmem[c]});
  endtask

  task automatic send_cmd(input logic [6:0] a, input logic [7:0] c);
    bit ack;
    int v0;
    v0 = vcount;
    bus_start();
    wbyte({a, 1'b0}, 1'b0, ack);
    wbyte(c, 1'b0, ack);
    bus_stop(); qd();
    chk(reg_addr == c, "R4", {8'd0, reg_addr}, {8'd0, c});
    chk(vcount == v0 + 1, "R10", 16'(vcount - v0), 16'd1);
  endtask

  task automatic recv(input logic [6:0] a, input logic [7:0] c);
    bit ack;
    logic [7:0] d;
    bus_start();
    wbyte({a, 1'b1}, 1'b0, ack);
    rbyte(d, 1'b0);
    bus_stop(); qd();
    chk(d == expmem[c], "R6", {8'd0, d}, {8'd0, expmem[c]});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      expmem[i] = 8'(i) ^ 8'hA5;
    end
    do_reset(2'd0);
    chk(!sda_oe && !reg_we && !valid_txn && reg_addr == 8'h00, "R1 reset",
        {12'd0, sda_oe, reg_we, valid_txn, 1'b0}, 16'd0);

    // R1 ground strap, R3 writes with several patterns
    wr_reg(7'h50, 8'h03, 8'h3C, 1'b1, 1'b0, "R1");
    wr_reg(7'h50, 8'h07, 8'h00, 1'b1, 1'b0, "R3");
    wr_reg(7'h50, 8'hFE, 8'hFF, 1'b1, 1'b0, "R3");
    rd_reg(7'h50, 8'h03);
    rd_reg(7'h50, 8'h07);
    rd_reg(7'h50, 8'hFE);
    rd_reg(7'h50, 8'h11);

    // R4 / R6: pointer-only command then pointer-only read
    send_cmd(7'h50, 8'h07);
    recv(7'h50, 8'h07);
    send_cmd(7'h50, 8'hFE);
    recv(7'h50, 8'hFE);

    // R2: foreign address is not acknowledged and has no effect
    wr_reg(7'h51, 8'h20, 8'h99, 1'b0, 1'b0, "R2");
    chk(reg_addr == 8'hFE, "R2 pointer", {8'd0, reg_addr}, 16'h00FE);

    // R1: strap changes after capture are ignored
    strap = 2'd2;
    repeat (10) @(negedge clk);
    wr_reg(7'h54, 8'h21, 8'h12, 1'b0, 1'b0, "R1 late strap");
    wr_reg(7'h50, 8'h21, 8'h12, 1'b1, 1'b0, "R1 held");

    // R8: short glitches on SCL and SDA within a write
    wr_reg(7'h50, 8'h30, 8'h5A, 1'b1, 1'b1, "R8");
    rd_reg(7'h50, 8'h30);

    // R1: open strap and supply strap
    do_reset(2'd1);
    wr_reg(7'h52, 8'h40, 8'hC3, 1'b1, 1'b0, "R1 open");
    wr_reg(7'h50, 8'h41, 8'h01, 1'b0, 1'b0, "R1 open-other");
    do_reset(2'd2);
    wr_reg(7'h54, 8'h42, 8'h81, 1'b1, 1'b0, "R1 supply");
    rd_reg(7'h54, 8'h40);

    // R9: master stalls SCL high while the slave holds its acknowledge
    begin
      bit ack;
      int v0;
      v0 = vcount;
      bus_start();
      for (int i = 7; i >= 0; i--) wbit(8'hA8 >> i, 1'b0);
      sda_m = 1'b1; qd(); scl_m = 1'b1; qd();
      chk(sda_line == 1'b0, "R9 ack held", {15'd0, sda_line}, 16'd0);
      repeat (TMO + 500) @(negedge clk);
      chk(sda_line == 1'b1 && !sda_oe, "R9 release", {15'd0, sda_line}, 16'd1);
      scl_m = 1'b0; qd();
      bus_stop(); qd();
      chk(vcount == v0, "R9 no pulse", 16'(vcount - v0), 16'd0);
      wr_reg(7'h54, 8'h43, 8'h77, 1'b1, 1'b0, "R9 recover");
      ack = 1'b0;
    end

    repeat (50) @(negedge clk);
    chk(wq.size() == 0, "R3 pending", 16'(wq.size()), 16'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks + m_checks, errs + m_errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks + m_checks + 1, errs + m_errs + 1);
      $finish;
    end
  end
endmodule